// File: doc/BRIEF.md
# SPI Register Access Command Sequencer

This block is an SPI master that sends configuration traffic to an external multi-channel converter front end. A host presents one request at a time: a register write, a register read, or a single-byte control command. The block turns that request into a fixed byte frame, shifts it out with chip select held low for the whole frame, and finishes with a one-cycle done pulse. On a read, the value the converter returns is presented on `rd_data` together with done.

Register frames carry the register address in the low five bits of the first byte. The second byte is a count field of the form 000nnnnn, always zero here because only single registers are accessed. The third byte is either the value to write or, on a read, a dummy byte that clocks the register value back in. After a read, chip select is held low for a programmable number of system cycles before it is released.

The block also tracks the converter's streaming mode. Once the stream-on command has been sent, register reads and writes are refused with an error until the stream-off command has been sent.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: A register write (req_op=0) sends exactly three bytes: 8'h40 OR the 5-bit address, then 8'h00, then req_wdata.
- R2: A register read (req_op=1) sends 8'h20 OR the 5-bit address, then 8'h00, then a dummy 8'h00. rd_data, valid while done is high, equals the byte received during the third byte.
- R3: A control request (req_op=2 or 3) sends exactly one byte, req_wdata. The recognised codes are 8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h10, 8'h11 and 8'h12.
- R4: spi_csn goes low before the first SCLK rising edge and stays low until after the last SCLK falling edge of the frame. spi_sclk stays low whenever spi_csn is high.
- R5: After the last byte of a read, spi_csn stays low for at least HOLD_CYC system cycles before it rises. After a write, it rises within four cycles.
- R6: The serial link runs in SPI mode 1, MSB first. SCLK idles low, MOSI changes only on the rising edge, and MISO is sampled on the falling edge. Each SCLK half period lasts HALF_DIV system cycles.
- R7: req_ready is high only while idle, and a request is taken when req_valid and req_ready are both high. done is a one-cycle pulse, asserted in the same cycle that spi_csn returns high.
- R8: Completing control code 8'h10 sets stream_mode, and completing 8'h11 clears it. While stream_mode is set, a read or write request drives no SPI activity; it ends the next cycle with done and err both high. Control requests are still sent while stream_mode is set.
- R9: err is low with done for every request that was sent on the link.
- R10: During and after reset, spi_csn=1, spi_sclk=0, req_ready=1, done=0 and stream_mode=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 write, 1 read, 2/3 control command |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write value or control code |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (valid with done) |
| rd_data | output | 8 | Register value read (valid with done) |
| stream_mode | output | 1 | Streaming mode active |
| spi_sclk | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The embedded assertions watch the link and handshake invariants on every cycle. They check that SCLK is quiet while deselected, that MOSI holds steady through each high phase, that done lasts a single cycle, that req_ready is low during a frame, and that a refused request never touches chip select. The byte contents of each frame, the captured read value, the length of the post-read hold and the set and clear of streaming mode depend on request history. These are shown only by the bench's scenarios, which run a mode-1 slave model and compare the decoded bytes with a queue of expected frames.

// File: rtl/spi_seq_pkg.sv
// Shared constants for the SPI command sequencer.
// Assumes: opcode values are fixed by the attached converter.
package spi_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_CTRL  = 2'd2,
        OP_CTRL2 = 2'd3
    } req_op_e;

    localparam logic [7:0] OPC_REG_RD     = 8'h20;
    localparam logic [7:0] OPC_REG_WR     = 8'h40;
    localparam logic [7:0] CODE_STREAM_ON = 8'h10;
    localparam logic [7:0] CODE_STREAM_OFF = 8'h11;
    localparam logic [7:0] COUNT_ONE_REG  = 8'h00;
    localparam logic [7:0] FILL_BYTE      = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_HOLD,
        ST_END,
        ST_REFUSE
    } seq_state_e;

endpackage

// File: rtl/spi_byte_shifter.sv
// Mode-1 SPI byte shifter (CPOL=0, CPHA=1), MSB first.
// Does: on start, runs eight SCLK periods; drives MOSI on each rising
// edge and samples MISO on each falling edge; pulses byte_done after
// the eighth falling edge, with rx_byte then complete.
// Assumes: start is only raised while busy is low; HALF_DIV >= 1.
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;

    // Half-period timer, SCLK phase, data shift and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            byte_done <= 1'b0;
            div_cnt   <= '0;
            bit_idx   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    tx_sh   <= tx_byte;
                    div_cnt <= DIV_LAST;
                    bit_idx <= '0;
                end
            end else if (div_cnt != '0) begin
                div_cnt <= div_cnt - 1'b1;
            end else begin
                div_cnt <= DIV_LAST;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    mosi  <= tx_sh[7];
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end else begin
                    sclk    <= 1'b0;
                    rx_sh   <= {rx_sh[6:0], miso};
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end
            end
        end
    end

    assign rx_byte = rx_sh;

    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!busy && !sclk)); // R6

endmodule

// File: rtl/seq_frame_ctrl.sv
// Transaction controller for the SPI command sequencer.
// Does: accepts one request when idle, builds its byte frame, feeds the
// shifter one byte at a time with chip select low, holds chip select
// after a read, releases it with a done pulse, and tracks streaming mode.
// Assumes: shifter accepts start only while idle and pulses byte_done.
module seq_frame_ctrl
    import spi_seq_pkg::*;
#(
    parameter int HOLD_CYC = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_op,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       done,
    output logic       err,
    output logic [7:0] rd_data,
    output logic       stream_mode,
    output logic       csn,
    output logic       sh_start,
    output logic [7:0] sh_tx,
    input  logic       sh_done,
    input  logic [7:0] sh_rx
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    seq_state_e        state;
    logic [2:0][7:0]   frame;
    logic [1:0]        idx;
    logic [1:0]        last_idx;
    logic              is_read;
    logic              is_ctrl;
    logic [HOLD_W-1:0] hold_cnt;
    logic              accept;
    logic              reg_op;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign reg_op    = (req_op == OP_WRITE) || (req_op == OP_READ);
    assign sh_start  = (state == ST_LOAD);
    assign sh_tx     = frame[idx];

    // Sequencing of request intake, byte issue, hold and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            frame       <= '0;
            idx         <= '0;
            last_idx    <= '0;
            is_read     <= 1'b0;
            is_ctrl     <= 1'b0;
            hold_cnt    <= '0;
            csn         <= 1'b1;
            done        <= 1'b0;
            err         <= 1'b0;
            rd_data     <= '0;
            stream_mode <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        is_read <= (req_op == OP_READ);
                        is_ctrl <= !reg_op;
                        idx     <= '0;
                        if (reg_op && stream_mode) begin
                            state <= ST_REFUSE;
                        end else if (!reg_op) begin
                            frame    <= {FILL_BYTE, FILL_BYTE, req_wdata};
                            last_idx <= 2'd0;
                            csn      <= 1'b0;
                            state    <= ST_LOAD;
                        end else begin
                            frame[0] <= ((req_op == OP_READ) ? OPC_REG_RD : OPC_REG_WR)
                                        | {3'b000, req_addr};
                            frame[1] <= COUNT_ONE_REG;
                            frame[2] <= (req_op == OP_READ) ? FILL_BYTE : req_wdata;
                            last_idx <= 2'd2;
                            csn      <= 1'b0;
                            state    <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (sh_done) begin
                        if (idx != last_idx) begin
                            idx   <= idx + 1'b1;
                            state <= ST_LOAD;
                        end else if (is_read) begin
                            rd_data  <= sh_rx;
                            hold_cnt <= HOLD_LAST;
                            state    <= ST_HOLD;
                        end else begin
                            state <= ST_END;
                        end
                    end
                end
                ST_HOLD: begin
                    if (hold_cnt == '0) state <= ST_END;
                    else hold_cnt <= hold_cnt - 1'b1;
                end
                ST_END: begin
                    csn   <= 1'b1;
                    done  <= 1'b1;
                    err   <= 1'b0;
                    state <= ST_IDLE;
                    if (is_ctrl && frame[0] == CODE_STREAM_ON)  stream_mode <= 1'b1;
                    if (is_ctrl && frame[0] == CODE_STREAM_OFF) stream_mode <= 1'b0;
                end
                ST_REFUSE: begin
                    done  <= 1'b1;
                    err   <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !csn |-> !req_ready); // R7

    AST_REFUSE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (csn && $past(csn))); // R8

    AST_REFUSE_ONLY_STREAMING: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> stream_mode); // R8

    AST_NO_START_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !csn); // R4

endmodule

// File: rtl/spi_cmd_sequencer.sv
// Top of the SPI register access command sequencer.
// Does: joins the frame controller to the mode-1 byte shifter.
// Assumes: one external converter on the link; single-register access.
module spi_cmd_sequencer #(
    parameter int HALF_DIV = 2,
    parameter int HOLD_CYC = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_op,
    input  logic [4:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       done,
    output logic       err,
    output logic [7:0] rd_data,
    output logic       stream_mode,
    output logic       spi_sclk,
    output logic       spi_csn,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_busy;
    logic       sh_done;
    logic [7:0] sh_rx;

    seq_frame_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .done        (done),
        .err         (err),
        .rd_data     (rd_data),
        .stream_mode (stream_mode),
        .csn         (spi_csn),
        .sh_start    (sh_start),
        .sh_tx       (sh_tx),
        .sh_done     (sh_done),
        .sh_rx       (sh_rx)
    );

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .busy      (sh_busy),
        .byte_done (sh_done),
        .rx_byte   (sh_rx),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso)
    );

    AST_SCLK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> (!spi_sclk && !sh_busy)); // R4

    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (spi_csn && !$past(spi_csn))); // R7

endmodule

// File: tb/spi_cmd_sequencer_test.sv
module spi_cmd_sequencer_test;
    localparam int HALF = 2;
    localparam int HOLD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [4:0] req_addr = 5'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       req_ready, done, err, stream_mode;
    logic [7:0] rd_data;
    logic       spi_sclk, spi_csn, spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_fall = 0;

    typedef struct {
        logic       exp_err;
        logic       is_read;
        logic [7:0] exp_rd;
    } result_t;

    typedef struct {
        logic [7:0] val;
        int         req;
    } byte_t;

    result_t res_q[$];
    byte_t   byte_q[$];

    logic [23:0] slave_word = '0;
    int          sbit = 0;
    logic [7:0]  mon_sh = '0;
    int          mon_bits = 0;
    logic        cs_seen = 1'b0;

    spi_cmd_sequencer #(.HALF_DIV(HALF), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .err(err), .rd_data(rd_data), .stream_mode(stream_mode),
        .spi_sclk(spi_sclk), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slave model: mode 1, next bit on rising SCLK.
    always @(negedge spi_csn) begin
        sbit = 0;
        cs_seen = 1'b1;
    end
    always @(posedge spi_sclk) begin
        spi_miso <= slave_word[23 - (sbit % 24)];
        sbit = sbit + 1;
    end

    // MOSI monitor: sample on falling SCLK, compare per byte.
    always @(negedge spi_sclk) begin
        last_fall = cyc;
        check(spi_csn == 1'b0, "R4 sclk edge while selected", spi_csn, 0);
        mon_sh = {mon_sh[6:0], spi_mosi};
        mon_bits = mon_bits + 1;
        if (mon_bits == 8) begin
            mon_bits = 0;
            if (byte_q.size() == 0) begin
                check(1'b0, "R3 unexpected extra byte", mon_sh, 0);
            end else begin
                byte_t b;
                b = byte_q.pop_front();
                if (b.req == 1)      check(mon_sh == b.val, "R1 write frame byte", mon_sh, b.val);
                else if (b.req == 2) check(mon_sh == b.val, "R2 read frame byte", mon_sh, b.val);
                else                 check(mon_sh == b.val, "R3 control byte", mon_sh, b.val);
            end
        end
    end

    // Result monitor: check each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (res_q.size() == 0) begin
                check(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                result_t r;
                r = res_q.pop_front();
                check(spi_csn == 1'b1, "R7 csn high with done", spi_csn, 1);
                if (r.exp_err) begin
                    check(err == 1'b1, "R8 refused request flags err", err, 1);
                    check(!cs_seen && mon_bits == 0, "R8 refused request left link idle",
                          cs_seen, 0);
                end else begin
                    check(err == 1'b0, "R9 err low on sent request", err, 0);
                    check(byte_q.size() == 0, "R1 all frame bytes sent", byte_q.size(), 0);
                    if (r.is_read) begin
                        check(rd_data == r.exp_rd, "R2 read data", rd_data, r.exp_rd);
                        check((cyc - last_fall) >= HOLD, "R5 read hold length",
                              cyc - last_fall, HOLD);
                    end else begin
                        check((cyc - last_fall) <= 4, "R5 prompt release after write",
                              cyc - last_fall, 4);
                    end
                end
            end
        end
    end

    // Driver: push expectations, issue request, wait for completion.
    task automatic issue(input logic [1:0] op, input logic [4:0] addr,
                         input logic [7:0] wd, input logic [23:0] resp,
                         input logic refuse);
        result_t r;
        byte_t b;
        while (!req_ready) @(negedge clk);
        slave_word = resp;
        cs_seen = 1'b0;
        r.exp_err = refuse;
        r.is_read = (op == 2'd1);
        r.exp_rd  = resp[7:0];
        if (!refuse) begin
            if (op == 2'd0) begin
                b.req = 1;
                b.val = 8'h40 | {3'b000, addr}; byte_q.push_back(b);
                b.val = 8'h00;                  byte_q.push_back(b);
                b.val = wd;                     byte_q.push_back(b);
            end else if (op == 2'd1) begin
                b.req = 2;
                b.val = 8'h20 | {3'b000, addr}; byte_q.push_back(b);
                b.val = 8'h00;                  byte_q.push_back(b);
                b.val = 8'h00;                  byte_q.push_back(b);
            end else begin
                b.req = 3;
                b.val = wd; byte_q.push_back(b);
            end
        end
        res_q.push_back(r);
        req_op = op; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
        while (res_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(spi_csn == 1'b1, "R10 reset csn", spi_csn, 1);
        check(spi_sclk == 1'b0, "R10 reset sclk", spi_sclk, 0);
        check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        check(done == 1'b0, "R10 reset done", done, 0);
        check(stream_mode == 1'b0, "R10 reset stream mode", stream_mode, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(spi_sclk == 1'b0 && spi_csn == 1'b1, "R6 sclk idles low", spi_sclk, 0);

        issue(2'd0, 5'h05, 8'hE0, 24'h0, 1'b0);          // R1
        issue(2'd0, 5'h1F, 8'hA5, 24'h0, 1'b0);          // R1 high address
        issue(2'd1, 5'h00, 8'h00, 24'h12343E, 1'b0);     // R2 R5
        issue(2'd1, 5'h15, 8'h77, 24'hFF0081, 1'b0);     // R2 wdata ignored
        issue(2'd2, 5'h03, 8'h08, 24'h0, 1'b0);          // R3
        issue(2'd3, 5'h00, 8'h0A, 24'h0, 1'b0);          // R3 second ctrl code
        check(stream_mode == 1'b0, "R8 other codes leave stream mode", stream_mode, 0);
        issue(2'd2, 5'h00, 8'h10, 24'h0, 1'b0);          // R8 stream on
        check(stream_mode == 1'b1, "R8 stream mode set", stream_mode, 1);
        issue(2'd0, 5'h06, 8'h11, 24'h0, 1'b1);          // R8 write refused
        issue(2'd1, 5'h06, 8'h00, 24'h0, 1'b1);          // R8 read refused
        issue(2'd2, 5'h00, 8'h12, 24'h0, 1'b0);          // R8 ctrl still sent
        check(stream_mode == 1'b1, "R8 stream mode kept", stream_mode, 1);
        issue(2'd2, 5'h00, 8'h11, 24'h0, 1'b0);          // R8 stream off
        check(stream_mode == 1'b0, "R8 stream mode cleared", stream_mode, 0);
        issue(2'd0, 5'h15, 8'h20, 24'h0, 1'b0);          // R9 writes allowed again
        issue(2'd1, 5'h17, 8'h00, 24'hAA55C3, 1'b0);     // R2 R6

        repeat (5) @(negedge clk);
        check(res_q.size() == 0 && byte_q.size() == 0, "R7 all results seen",
              res_q.size() + byte_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule